// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the common and segment drive levels for a three-phase multiplexed liquid-crystal panel with up to 35 segment lines. A free-running oscillator enable advances an internal frame timer; each frame is divided evenly into three common phases, and every level inverts polarity on alternate frames so that the average voltage across each pixel is zero. Each output is a 2-bit code naming a supply tap: 0 for ground, 1 for one third, 2 for two thirds and 3 for the full LCD supply. The analog switches and bias dividers sit outside the block.

A 105-bit display image supplies three on/off bits per segment line, one for each phase. A mode bit picks between one-third and one-half bias. Three controls override the outputs: segment blanking, power saving and inhibit. Each acts in a different way. A port count turns the lowest segment lines into static general-purpose outputs.

Top module: `lcd_mux_drive`

## Requirements
- R1: After reset the frame timer is at tick 0 of phase 0 with positive polarity, so common 0 is at level 3 and the other commons are at level 1 (one-third bias, outputs enabled).
- R2: Each enabled oscillator tick (osc_en high, pwr_save low) advances the timer. Common 0, then 1, then 2 are each selected for FRAME_DIV/3 ticks. With osc_en low the timer holds.
- R3: Polarity flips each FRAME_DIV ticks. The selected common is at level 3 in positive frames and 0 in negative frames.
- R4: With one-third bias (bias_half=0), the unselected commons are at level 1 in positive frames and 2 in negative frames. A lit segment is at 0 (positive) or 3 (negative). An unlit segment is at 2 (positive) or 1 (negative).
- R5: With one-half bias (bias_half=1), the unselected commons are at level 2. A lit segment is at 0 (positive) or 3 (negative). An unlit segment equals the selected common's level.
- R6: During phase p (0..2), segment line n (0..34) is lit when image bit 3n+p is 1.
- R7: With seg_off=1 every segment line shows the unlit level in every phase, while the commons keep scanning.
- R8: With pwr_save=1 the timer stops and every common and segment output is at level 0. Lines set as ports keep driving their data.
- R9: With inh_n=0 every output, ports included, is at level 0. The timer keeps running.
- R10: port_code gives the number of port lines counting from line 0. Values above 8 act as 8.
- R11: Port line k (0..7) outputs level 3 when image bit 3k is 1 and level 0 otherwise, regardless of phase, polarity, bias and seg_off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator tick enable |
| disp_img | input | 105 | Display image, bit 3n+p for line n in phase p |
| bias_half | input | 1 | 1 selects one-half bias, 0 one-third bias |
| seg_off | input | 1 | Blank all segment lines |
| pwr_save | input | 1 | Power-save mode |
| inh_n | input | 1 | Active-low inhibit |
| port_code | input | 4 | Number of lowest lines used as ports |
| com_lvl | output | 6 | Common levels, common c at bits [2c+1:2c] |
| seg_lvl | output | 70 | Segment levels, line n at bits [2n+1:2n] |

## Verification
A wrong phase or polarity register shows on the very next enabled tick as a common that sits at an extreme level out of turn, or as a segment level of the wrong sign. A timer that drifts, or that keeps running during power save, shows within one phase length once the bench's tick count and the design's scan disagree. A faulty override or port decode is visible in the same cycle that the control input changes.

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive #(
  parameter int NSEG      = 35,
  parameter int NPORT     = 8,
  parameter int FRAME_DIV = 384,
  parameter int PCW       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_en,
  input  logic [3*NSEG-1:0]    disp_img,
  input  logic                 bias_half,
  input  logic                 seg_off,
  input  logic                 pwr_save,
  input  logic                 inh_n,
  input  logic [PCW-1:0]       port_code,
  output logic [5:0]           com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl
);
  localparam int PH_LEN = FRAME_DIV / 3;
  localparam int TW     = $clog2(PH_LEN);
  localparam logic [TW-1:0] TICK_LAST = TW'(PH_LEN - 1);
  localparam logic [PCW-1:0] PMAX = PCW'(NPORT);

  logic [TW-1:0] tick;
  logic [1:0]    phase;
  logic          neg;
  logic          run;
  logic          active;
  logic [PCW-1:0] nport;

  assign run    = osc_en && !pwr_save;
  assign active = inh_n && !pwr_save;
  assign nport  = (port_code > PMAX) ? PMAX : port_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick  <= '0;
      phase <= 2'd0;
      neg   <= 1'b0;
    end else if (run) begin
      if (tick == TICK_LAST) begin
        tick <= '0;
        if (phase == 2'd2) begin
          phase <= 2'd0;
          neg   <= ~neg;
        end else begin
          phase <= phase + 2'd1;
        end
      end else begin
        tick <= tick + TW'(1);
      end
    end
  end

  logic [1:0] sel_lvl, idle_lvl, lit_lvl, dark_lvl;
  assign sel_lvl  = neg ? 2'd0 : 2'd3;
  assign idle_lvl = bias_half ? 2'd2 : (neg ? 2'd2 : 2'd1);
  assign lit_lvl  = neg ? 2'd3 : 2'd0;
  assign dark_lvl = bias_half ? sel_lvl : (neg ? 2'd1 : 2'd2);

  for (genvar c = 0; c < 3; c++) begin : g_com
    assign com_lvl[2*c +: 2] = !active ? 2'd0 :
                               (phase == 2'(c)) ? sel_lvl : idle_lvl;
  end

  for (genvar n = 0; n < NSEG; n++) begin : g_seg
    logic [2:0] trip;
    logic       bit_on;
    logic [1:0] wave;
    assign trip   = disp_img[3*n +: 3];
    assign bit_on = (phase == 2'd2) ? trip[2] :
                    (phase == 2'd1) ? trip[1] : trip[0];
    assign wave   = (bit_on && !seg_off) ? lit_lvl : dark_lvl;
    if (n < NPORT) begin : g_port
      logic is_port;
      assign is_port = inh_n && (PCW'(n) < nport);
      assign seg_lvl[2*n +: 2] = is_port ? (trip[0] ? 2'd3 : 2'd0) :
                                 active  ? wave : 2'd0;
    end else begin : g_plain
      assign seg_lvl[2*n +: 2] = active ? wave : 2'd0;
    end
  end
endmodule

module lcd_mux_drive_chk #(
  parameter int NSEG = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osc_en,
  input logic              bias_half,
  input logic              seg_off,
  input logic              pwr_save,
  input logic              inh_n,
  input logic [3:0]        port_code,
  input logic [5:0]        com_lvl,
  input logic [2*NSEG-1:0] seg_lvl
);
  logic [2:0] ext;
  logic       half_third;
  logic       dark_ok;
  always_comb begin
    half_third = 1'b0;
    for (int c = 0; c < 3; c++) begin
      ext[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
      if (com_lvl[2*c +: 2] == 2'd1) half_third = 1'b1;
    end
    dark_ok = 1'b1;
    for (int n = 0; n < NSEG; n++)
      if (seg_lvl[2*n +: 2] == 2'd0 || seg_lvl[2*n +: 2] == 2'd3) dark_ok = 1'b0;
  end

  AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_n && !pwr_save) |-> $countones(ext) == 1); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(osc_en) && $stable(bias_half) && $stable(inh_n) && $stable(pwr_save))
      |-> $stable(com_lvl)); // R2
  AST_HALF_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_half && inh_n && !pwr_save) |-> !half_third); // R5
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_off && !bias_half && inh_n && !pwr_save && port_code == 4'd0) |-> dark_ok); // R7
  AST_SAVE_GROUND: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save |-> com_lvl == 6'd0); // R8
  AST_INHIBIT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |-> (com_lvl == 6'd0 && seg_lvl == '0)); // R9
endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bias_half(bias_half),
  .seg_off(seg_off), .pwr_save(pwr_save), .inh_n(inh_n),
  .port_code(port_code), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/tb_lcd_mux_drive.sv
module tb_lcd_mux_drive;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 35;
  localparam int DIV  = 12;
  localparam int PH   = DIV / 3;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              osc_en = 0;
  logic [3*NSEG-1:0] disp_img = '0;
  logic              bias_half = 0;
  logic              seg_off = 0;
  logic              pwr_save = 0;
  logic              inh_n = 1;
  logic [3:0]        port_code = 0;
  logic [5:0]        com_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  int total = 0;
  int bad = 0;
  int ticks = 0;
  bit done = 0;

  lcd_mux_drive #(.FRAME_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .disp_img(disp_img),
    .bias_half(bias_half), .seg_off(seg_off), .pwr_save(pwr_save),
    .inh_n(inh_n), .port_code(port_code), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk)
    if (!rst_n) ticks <= 0;
    else if (osc_en && !pwr_save) ticks <= ticks + 1;

  function automatic logic [5:0] exp_com();
    int ph = (ticks / PH) % 3;
    int ng = (ticks / DIV) % 2;
    logic [5:0] v;
    for (int c = 0; c < 3; c++) begin
      if (!inh_n || pwr_save) v[2*c +: 2] = 0;
      else if (c == ph) v[2*c +: 2] = ng ? 2'd0 : 2'd3;
      else if (bias_half) v[2*c +: 2] = 2'd2;
      else v[2*c +: 2] = ng ? 2'd2 : 2'd1;
    end
    return v;
  endfunction

  function automatic logic [2*NSEG-1:0] exp_seg();
    int ph = (ticks / PH) % 3;
    int ng = (ticks / DIV) % 2;
    int np = (port_code > 8) ? 8 : int'(port_code);
    logic [2*NSEG-1:0] v;
    for (int n = 0; n < NSEG; n++) begin
      logic [1:0] lv;
      if (disp_img[3*n+ph] && !seg_off) lv = ng ? 2'd3 : 2'd0;
      else if (bias_half) lv = ng ? 2'd0 : 2'd3;
      else lv = ng ? 2'd1 : 2'd2;
      if (inh_n && n < np) lv = disp_img[3*n] ? 2'd3 : 2'd0;
      else if (!inh_n || pwr_save) lv = 2'd0;
      v[2*n +: 2] = lv;
    end
    return v;
  endfunction

  task automatic check(input string req);
    logic [5:0] ec = exp_com();
    logic [2*NSEG-1:0] es = exp_seg();
    total++;
    if (com_lvl !== ec || seg_lvl !== es) begin
      bad++;
      $display("FAIL %s t=%0d com act=%h exp=%h seg act=%h exp=%h",
               req, ticks, com_lvl, ec, seg_lvl, es);
    end
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req);
    end
  endtask

  function automatic logic [3*NSEG-1:0] pattern(input int k);
    logic [3*NSEG-1:0] v;
    for (int i = 0; i < 3*NSEG; i++) v[i] = ((i * 7 + k * 3) % (k + 2)) == 0;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1");
    osc_en = 1;
    // R2 R3 R4 R6: one-third bias sweep over images
    for (int k = 0; k < 4; k++) begin
      disp_img = pattern(k);
      run(2 * DIV + 3, "R4_R6_R3");
    end
    // R5: one-half bias
    bias_half = 1;
    for (int k = 0; k < 3; k++) begin
      disp_img = pattern(k + 4);
      run(2 * DIV + 1, "R5_R6");
    end
    // R2: oscillator enable low holds the timer
    @(negedge clk); osc_en = 0;
    run(PH + 2, "R2");
    osc_en = 1;
    run(PH, "R2");
    // R7: blanking in both bias modes
    disp_img = '1;
    seg_off = 1;
    run(2 * DIV, "R7");
    bias_half = 0;
    run(2 * DIV, "R7");
    seg_off = 0;
    // R10 R11: every port code, with and without blanking
    disp_img = pattern(2);
    for (int p = 0; p < 16; p++) begin
      port_code = 4'(p);
      seg_off = p[0];
      bias_half = p[1];
      run(PH + 1, "R10_R11");
    end
    seg_off = 0;
    // R8: power save holds the timer, ports live
    port_code = 4'd3;
    disp_img = '1;
    pwr_save = 1;
    run(DIV, "R8");
    disp_img = pattern(1);
    run(3, "R8");
    pwr_save = 0;
    run(DIV, "R8");
    // R9: inhibit clears ports too, timer keeps running
    port_code = 4'd5;
    disp_img = '1;
    inh_n = 0;
    run(DIV + 2, "R9");
    inh_n = 1;
    run(DIV, "R9");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule